// File: doc/BRIEF.md
# Segment Selector Translation Unit

This unit converts a segment-relative access (a segment register number plus a 32-bit offset) into a flat linear address. It also enforces the protection rules attached to each segment. A descriptor table base and limit register locates the global table in memory. Software loads a 16-bit selector into one of several segment registers. The unit then checks the selector, reads the 8-byte descriptor it names, and judges presence and privilege. A descriptor that passes is kept in a hidden cache entry for that register.

Accesses never touch memory. They use the hidden entry to add base and offset, compare the offset against the limit (scaled by 4 KB when the descriptor is granular), and refuse writes the descriptor does not allow. Every load and every access ends in a one-cycle completion pulse with a 3-bit fault code. Zero means success.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, `busy`, `mem_rd_valid`, `ld_done` and `acc_done` are all low, and every segment register is unloaded.
- R2: A load whose selector has bit 2 set (local table) completes one cycle after acceptance with fault code 1, and no memory read is issued.
- R3: A load whose selector index (bits 15:3), times 8 plus 7, exceeds the table limit register completes one cycle after acceptance with fault code 2, and no memory read is issued. A span exactly equal to the limit is allowed.
- R4: Any other load reads two 32-bit words through a valid/ready port, first at table base + 8*index and then at that address + 4. Address and valid hold while ready is low. `busy` stays high from acceptance until the cycle of `ld_done`. The upper word holds limit in bits 19:0, type in 23:20 (bit 23 marks code, bit 21 is write permission for data), privilege level in 25:24, present in 26 and granularity in 27. The lower word is the base.
- R5: A fetched descriptor with the present bit clear gives fault code 3.
- R6: A present descriptor is refused with fault code 4 when the larger of the current privilege level and the selector's bits 1:0 is numerically greater than the descriptor level. Equality passes.
- R7: An access completes one cycle after `acc_valid`. On success `acc_lin_addr` is cached base + offset modulo 2^32. On any fault it is zero.
- R8: An offset above the effective limit gives fault code 5. The effective limit is the raw limit, or when granular the raw limit shifted left by 12 with ones filled in below.
- R9: A write within the limit to a code segment, or to a data segment without write permission, gives fault code 6. A limit fault takes priority.
- R10: An access to a register never loaded successfully gives fault code 7. A load that faults leaves the register's previous cache entry unchanged.
- R11: An access presented in the same cycle that a load of the same register completes uses the entry as it was before that load.
- R12: A load request presented while `busy` is high is ignored: it produces no completion and no change to any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Write the descriptor table register |
| tbl_base_in | input | 32 | New table base address |
| tbl_limit_in | input | 16 | New table limit (last valid byte offset) |
| ld_valid | input | 1 | Load request |
| ld_seg | input | 2 | Segment register to load |
| ld_sel | input | 16 | Selector to load |
| ld_cpl | input | 2 | Current privilege level for this load |
| busy | output | 1 | Descriptor fetch in progress |
| ld_done | output | 1 | Load completion pulse |
| ld_fault | output | 3 | Load fault code, valid with `ld_done` |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the request |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data |
| acc_valid | input | 1 | Access request |
| acc_seg | input | 2 | Segment register used by the access |
| acc_offset | input | 32 | Offset within the segment |
| acc_write | input | 1 | Access is a write |
| acc_done | output | 1 | Access completion pulse |
| acc_fault | output | 3 | Access fault code, valid with `acc_done` |
| acc_lin_addr | output | 32 | Linear address, valid with `acc_done` |

## Verification
A load completing and an access to the same segment register can land in the same clock edge. In that case the access has to see the old hidden entry and not the one being written. The bench's memory responder provokes this: when it returns the second descriptor word of a load, it presents an access to that register in the same cycle. The expected result is computed from the reference model's entry before the load is recorded. A follow-up access then confirms that the new descriptor took effect.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [2:0] {
      FLT_NONE      = 3'd0,
      FLT_LOCAL     = 3'd1,
      FLT_TBL_BOUND = 3'd2,
      FLT_ABSENT    = 3'd3,
      FLT_PRIV      = 3'd4,
      FLT_LIMIT     = 3'd5,
      FLT_PROT      = 3'd6,
      FLT_UNLOADED  = 3'd7
   } seg_fault_e;

   // Upper descriptor word field positions
   localparam int DW_LIM_LSB  = 0;
   localparam int DW_LIM_W    = 20;
   localparam int DW_KIND_LSB = 20;
   localparam int DW_DPL_LSB  = 24;
   localparam int DW_PRES_BIT = 26;
   localparam int DW_GRAN_BIT = 27;
   // Bits inside the type field
   localparam int KIND_CODE_BIT = 3;
   localparam int KIND_WR_BIT   = 1;

   typedef struct packed {
      logic [31:0]         base;
      logic [DW_LIM_W-1:0] limit;
      logic                code;
      logic                wr_ok;
      logic                gran;
   } seg_entry_t;

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
   import seg_xlate_pkg::*;
#(
   parameter int SEL_W  = 16,
   parameter int ADDR_W = 32
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic [SEL_W-1:0]  tbl_limit,
   output logic              pre_fault,
   output seg_fault_e        pre_code,
   output logic [1:0]        rpl,
   output logic [ADDR_W-1:0] desc_addr
);
   localparam int IDX_W = SEL_W - 3;

   logic [IDX_W-1:0] idx;
   logic             local_tbl;
   logic [SEL_W-1:0] span_end;

   assign idx       = sel[SEL_W-1:3];
   assign local_tbl = sel[2];
   assign rpl       = sel[1:0];
   assign span_end  = {idx, 3'b111};
   assign desc_addr = tbl_base + ADDR_W'({idx, 3'b000});

   always_comb begin
      pre_fault = 1'b1;
      if (local_tbl)
         pre_code = FLT_LOCAL;
      else if (span_end > tbl_limit)
         pre_code = FLT_TBL_BOUND;
      else begin
         pre_code  = FLT_NONE;
         pre_fault = 1'b0;
      end
   end

endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
   import seg_xlate_pkg::*;
(
   input  logic [31:0] lo_word,
   input  logic [31:0] hi_word,
   input  logic [1:0]  cpl,
   input  logic [1:0]  rpl,
   output seg_entry_t  entry,
   output seg_fault_e  fault
);
   logic [1:0] dpl;
   logic [1:0] eff_pl;
   logic [3:0] kind;
   logic       present;
   logic       unused_bits;

   assign dpl     = hi_word[DW_DPL_LSB +: 2];
   assign kind    = hi_word[DW_KIND_LSB +: 4];
   assign present = hi_word[DW_PRES_BIT];
   assign eff_pl  = (cpl > rpl) ? cpl : rpl;
   assign unused_bits = ^{hi_word[31:28], kind[2], kind[0]};

   always_comb begin
      entry.base  = lo_word;
      entry.limit = hi_word[DW_LIM_LSB +: DW_LIM_W];
      entry.code  = kind[KIND_CODE_BIT];
      entry.wr_ok = kind[KIND_WR_BIT];
      entry.gran  = hi_word[DW_GRAN_BIT];
   end

   always_comb begin
      if (!present)
         fault = FLT_ABSENT;
      else if (eff_pl > dpl)
         fault = FLT_PRIV;
      else
         fault = FLT_NONE;
   end

endmodule

// File: rtl/seg_cache_bank.sv
module seg_cache_bank
   import seg_xlate_pkg::*;
#(
   parameter int NUM_SEGS   = 4,
   parameter int SEG_W      = 2,
   parameter int ADDR_W     = 32,
   parameter int GRAN_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEG_W-1:0]  wr_seg,
   input  seg_entry_t        wr_entry,
   input  logic              acc_valid,
   input  logic [SEG_W-1:0]  acc_seg,
   input  logic [ADDR_W-1:0] acc_offset,
   input  logic              acc_write,
   output logic              acc_done,
   output seg_fault_e        acc_fault,
   output logic [ADDR_W-1:0] acc_lin_addr
);
   localparam int LIM_W = DW_LIM_W;

   seg_entry_t            ent_q [NUM_SEGS];
   logic [NUM_SEGS-1:0]   vld_q;
   seg_entry_t            rd_ent;
   logic                  rd_vld;
   logic [ADDR_W-1:0]     eff_lim;
   seg_fault_e            chk_flt;

   for (genvar g = 0; g < NUM_SEGS; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[g] <= 1'b0;
            ent_q[g] <= '0;
         end else if (wr_en && (wr_seg == SEG_W'(g))) begin
            vld_q[g] <= 1'b1;
            ent_q[g] <= wr_entry;
         end
      end

      // R10
      ent_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$fell(vld_q[g]));
   end

   if (NUM_SEGS == 1) begin : g_rd_single
      logic unused_sel;
      assign unused_sel = ^acc_seg;
      assign rd_ent = ent_q[0];
      assign rd_vld = vld_q[0];
   end else begin : g_rd_mux
      always_comb begin
         rd_ent = '0;
         rd_vld = 1'b0;
         for (int i = 0; i < NUM_SEGS; i++) begin
            if (acc_seg == SEG_W'(i)) begin
               rd_ent = ent_q[i];
               rd_vld = vld_q[i];
            end
         end
      end
   end

   assign eff_lim = rd_ent.gran ? {rd_ent.limit, {GRAN_SHIFT{1'b1}}}
                                : ADDR_W'(rd_ent.limit);

   always_comb begin
      if (!rd_vld)
         chk_flt = FLT_UNLOADED;
      else if (acc_offset > eff_lim)
         chk_flt = FLT_LIMIT;
      else if (acc_write && (rd_ent.code || !rd_ent.wr_ok))
         chk_flt = FLT_PROT;
      else
         chk_flt = FLT_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_done     <= 1'b0;
         acc_fault    <= FLT_NONE;
         acc_lin_addr <= '0;
      end else begin
         acc_done <= acc_valid;
         if (acc_valid) begin
            acc_fault    <= chk_flt;
            acc_lin_addr <= (chk_flt == FLT_NONE) ? rd_ent.base + acc_offset : '0;
         end
      end
   end

   // R7
   acc_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> acc_done);

   // R7
   acc_zero_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_done && acc_fault != FLT_NONE) |-> (acc_lin_addr == '0));

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int NUM_SEGS   = 4,
   parameter int SEL_W      = 16,
   parameter int ADDR_W     = 32,
   parameter int GRAN_SHIFT = 12,
   localparam int SEG_W     = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_wr_en,
   input  logic [ADDR_W-1:0] tbl_base_in,
   input  logic [SEL_W-1:0]  tbl_limit_in,
   input  logic              ld_valid,
   input  logic [SEG_W-1:0]  ld_seg,
   input  logic [SEL_W-1:0]  ld_sel,
   input  logic [1:0]        ld_cpl,
   output logic              busy,
   output logic              ld_done,
   output logic [2:0]        ld_fault,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data,
   input  logic              acc_valid,
   input  logic [SEG_W-1:0]  acc_seg,
   input  logic [ADDR_W-1:0] acc_offset,
   input  logic              acc_write,
   output logic              acc_done,
   output logic [2:0]        acc_fault,
   output logic [ADDR_W-1:0] acc_lin_addr
);
   if (ADDR_W != 32) begin : g_bad_addr
      $error("seg_xlate_unit: descriptor words are 32 bits, ADDR_W must be 32");
   end
   if (DW_LIM_W + GRAN_SHIFT != ADDR_W) begin : g_bad_gran
      $error("seg_xlate_unit: limit width plus GRAN_SHIFT must equal ADDR_W");
   end
   if (SEL_W < 4) begin : g_bad_sel
      $error("seg_xlate_unit: selector needs index, table and privilege fields");
   end
   if (NUM_SEGS < 1) begin : g_bad_segs
      $error("seg_xlate_unit: NUM_SEGS must be at least 1");
   end

   typedef enum logic [2:0] {
      ST_IDLE, ST_REQ0, ST_WAIT0, ST_REQ1, ST_WAIT1
   } fetch_st_e;

   fetch_st_e         st_q;
   logic [ADDR_W-1:0] tbl_base_q;
   logic [SEL_W-1:0]  tbl_lim_q;
   logic [ADDR_W-1:0] addr_q;
   logic [31:0]       word0_q;
   logic [SEG_W-1:0]  seg_q;
   logic [1:0]        rpl_q;
   logic [1:0]        cpl_q;
   logic              done_q;
   seg_fault_e        flt_q;

   logic              pre_fault;
   seg_fault_e        pre_code;
   logic [1:0]        dec_rpl;
   logic [ADDR_W-1:0] dec_addr;
   seg_entry_t        chk_entry;
   seg_fault_e        chk_fault;
   logic              accept;
   logic              cache_we;
   seg_fault_e        acc_flt_e;

   seg_sel_decode #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_dec (
      .sel       (ld_sel),
      .tbl_base  (tbl_base_q),
      .tbl_limit (tbl_lim_q),
      .pre_fault (pre_fault),
      .pre_code  (pre_code),
      .rpl       (dec_rpl),
      .desc_addr (dec_addr)
   );

   seg_desc_check u_chk (
      .lo_word (word0_q),
      .hi_word (mem_rsp_data),
      .cpl     (cpl_q),
      .rpl     (rpl_q),
      .entry   (chk_entry),
      .fault   (chk_fault)
   );

   assign accept   = (st_q == ST_IDLE) && ld_valid;
   assign cache_we = (st_q == ST_WAIT1) && mem_rsp_valid && (chk_fault == FLT_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbl_base_q <= '0;
         tbl_lim_q  <= '0;
      end else if (tbl_wr_en) begin
         tbl_base_q <= tbl_base_in;
         tbl_lim_q  <= tbl_limit_in;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         word0_q <= '0;
         seg_q   <= '0;
         rpl_q   <= '0;
         cpl_q   <= '0;
         done_q  <= 1'b0;
         flt_q   <= FLT_NONE;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  seg_q <= ld_seg;
                  rpl_q <= dec_rpl;
                  cpl_q <= ld_cpl;
                  if (pre_fault) begin
                     done_q <= 1'b1;
                     flt_q  <= pre_code;
                  end else begin
                     addr_q <= dec_addr;
                     st_q   <= ST_REQ0;
                  end
               end
            end
            ST_REQ0: if (mem_rd_ready) st_q <= ST_WAIT0;
            ST_WAIT0: begin
               if (mem_rsp_valid) begin
                  word0_q <= mem_rsp_data;
                  addr_q  <= addr_q + ADDR_W'(4);
                  st_q    <= ST_REQ1;
               end
            end
            ST_REQ1: if (mem_rd_ready) st_q <= ST_WAIT1;
            ST_WAIT1: begin
               if (mem_rsp_valid) begin
                  done_q <= 1'b1;
                  flt_q  <= chk_fault;
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy         = (st_q != ST_IDLE);
   assign mem_rd_valid = (st_q == ST_REQ0) || (st_q == ST_REQ1);
   assign mem_rd_addr  = addr_q;
   assign ld_done      = done_q;
   assign ld_fault     = flt_q;

   seg_cache_bank #(
      .NUM_SEGS   (NUM_SEGS),
      .SEG_W      (SEG_W),
      .ADDR_W     (ADDR_W),
      .GRAN_SHIFT (GRAN_SHIFT)
   ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (cache_we),
      .wr_seg       (seg_q),
      .wr_entry     (chk_entry),
      .acc_valid    (acc_valid),
      .acc_seg      (acc_seg),
      .acc_offset   (acc_offset),
      .acc_write    (acc_write),
      .acc_done     (acc_done),
      .acc_fault    (acc_flt_e),
      .acc_lin_addr (acc_lin_addr)
   );
   assign acc_fault = acc_flt_e;

   // R4
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   // R2
   early_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && pre_fault) |=> (ld_done && !mem_rd_valid && !busy));

   // R5
   cache_wr_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cache_we |=> (ld_done && ld_fault == 3'd0));

   // R12
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ld_done && st_q != ST_WAIT1) |=> !ld_done);

endmodule

// File: tb/seg_xlate_unit_tb.sv
`timescale 1ns/1ps
module seg_xlate_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tbl_wr_en = 1'b0;
   logic [31:0] tbl_base_in = '0;
   logic [15:0] tbl_limit_in = '0;
   logic        ld_valid = 1'b0;
   logic [1:0]  ld_seg = '0;
   logic [15:0] ld_sel = '0;
   logic [1:0]  ld_cpl = '0;
   logic        busy;
   logic        ld_done;
   logic [2:0]  ld_fault;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b0;
   logic [31:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        acc_valid = 1'b0;
   logic [1:0]  acc_seg = '0;
   logic [31:0] acc_offset = '0;
   logic        acc_write = 1'b0;
   logic        acc_done;
   logic [2:0]  acc_fault;
   logic [31:0] acc_lin_addr;

   always #10 clk = ~clk;

   seg_xlate_unit u_dut (
      .clk(clk), .rst_n(rst_n),
      .tbl_wr_en(tbl_wr_en), .tbl_base_in(tbl_base_in), .tbl_limit_in(tbl_limit_in),
      .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_cpl(ld_cpl),
      .busy(busy), .ld_done(ld_done), .ld_fault(ld_fault),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .acc_valid(acc_valid), .acc_seg(acc_seg), .acc_offset(acc_offset),
      .acc_write(acc_write), .acc_done(acc_done), .acc_fault(acc_fault),
      .acc_lin_addr(acc_lin_addr)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int n_loads  = 0;
   int n_dones  = 0;

   // Reference model state
   logic [31:0] mem [int unsigned];
   logic [31:0] m_tbase = '0;
   logic [15:0] m_tlim  = '0;
   bit          m_vld  [4];
   logic [31:0] m_base [4];
   logic [31:0] m_elim [4];
   bit          m_code [4];
   bit          m_wr   [4];
   logic [31:0] exp_reads [$];

   // Collision stimulus shared with the responder
   bit          col_arm = 0;
   int          col_seg = 0;
   logic [31:0] col_off = '0;

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rd_mem(logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic put_desc(int idx, logic [31:0] base, logic [19:0] lim,
                           logic [3:0] kind, logic [1:0] dpl, bit pres, bit gran);
      mem[m_tbase + 32'(idx) * 8]     = base;
      mem[m_tbase + 32'(idx) * 8 + 4] = {4'b0, gran, pres, dpl, kind, lim};
   endtask

   function automatic int exp_load(logic [15:0] sel, logic [1:0] cpl);
      logic [31:0] hi;
      int epl;
      if (sel[2]) return 1;
      if ({sel[15:3], 3'b111} > m_tlim) return 2;
      hi  = rd_mem(m_tbase + {16'b0, sel[15:3], 3'b000} + 4);
      if (!hi[26]) return 3;
      epl = (cpl > sel[1:0]) ? int'(cpl) : int'(sel[1:0]);
      if (epl > int'(hi[25:24])) return 4;
      return 0;
   endfunction

   function automatic int exp_acc(int seg, logic [31:0] off, bit wr, output logic [31:0] la);
      la = '0;
      if (!m_vld[seg]) return 7;
      if (off > m_elim[seg]) return 5;
      if (wr && (m_code[seg] || !m_wr[seg])) return 6;
      la = m_base[seg] + off;
      return 0;
   endfunction

   task automatic set_table(logic [31:0] b, logic [15:0] l);
      @(negedge clk);
      tbl_wr_en = 1; tbl_base_in = b; tbl_limit_in = l;
      @(negedge clk);
      tbl_wr_en = 0;
      m_tbase = b; m_tlim = l;
   endtask

   task automatic do_load(int seg, logic [15:0] sel, logic [1:0] cpl, bit probe, string req);
      int exp;
      int guard;
      logic [31:0] a;
      logic [31:0] hi;
      exp = exp_load(sel, cpl);
      a   = m_tbase + {16'b0, sel[15:3], 3'b000};
      @(negedge clk);
      ld_valid = 1; ld_seg = 2'(seg); ld_sel = sel; ld_cpl = cpl;
      if (exp != 1 && exp != 2) begin
         exp_reads.push_back(a);
         exp_reads.push_back(a + 4);
      end
      n_loads++;
      @(negedge clk);
      if (probe) begin
         ld_sel = 16'h0004; ld_seg = 2'd3;   // would fault at once if accepted
      end else
         ld_valid = 0;
      guard = 0;
      while (!ld_done && guard < 60) begin
         chk(busy == 1'b1, {req, " busy during fetch"}, 32'(busy), 32'd1);
         @(negedge clk);
         ld_valid = 0;
         guard++;
      end
      ld_valid = 0;
      chk(ld_done == 1'b1, {req, " load completes"}, 32'(ld_done), 32'd1);
      chk(ld_fault == 3'(exp), {req, " load fault code"}, 32'(ld_fault), 32'(exp));
      chk(busy == 1'b0, {req, " idle at completion"}, 32'(busy), 32'd0);
      if (exp == 0) begin
         hi = rd_mem(a + 4);
         m_vld[seg]  = 1;
         m_base[seg] = rd_mem(a);
         m_elim[seg] = hi[27] ? {hi[19:0], 12'hFFF} : {12'h0, hi[19:0]};
         m_code[seg] = hi[23];
         m_wr[seg]   = hi[21];
      end
   endtask

   task automatic do_acc(int seg, logic [31:0] off, bit wr, string req);
      int exp;
      logic [31:0] la;
      exp = exp_acc(seg, off, wr, la);
      @(negedge clk);
      acc_valid = 1; acc_seg = 2'(seg); acc_offset = off; acc_write = wr;
      @(negedge clk);
      acc_valid = 0; acc_write = 0;
      chk(acc_done == 1'b1, {req, " access completes"}, 32'(acc_done), 32'd1);
      chk(acc_fault == 3'(exp), {req, " access fault code"}, 32'(acc_fault), 32'(exp));
      chk(acc_lin_addr == la, {req, " linear address"}, acc_lin_addr, la);
   endtask

   // Memory responder and same-cycle collision driver
   initial begin : responder
      bit          pend = 0;
      bit          pend_w1 = 0;
      int          dly = 0;
      int          rcnt = 0;
      int          rd_n = 0;
      logic [31:0] paddr = '0;
      bit          col_pend = 0;
      int          col_exp = 0;
      logic [31:0] col_la = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 0;
         if (col_pend) begin
            acc_valid = 0;
            col_pend  = 0;
            chk(acc_done == 1'b1, "R11 collide access completes", 32'(acc_done), 32'd1);
            chk(acc_fault == 3'(col_exp), "R11 collide fault uses old entry", 32'(acc_fault), 32'(col_exp));
            chk(acc_lin_addr == col_la, "R11 collide address uses old entry", acc_lin_addr, col_la);
         end
         if (pend) begin
            if (dly == 0) begin
               mem_rsp_valid = 1;
               mem_rsp_data  = rd_mem(paddr);
               pend = 0;
               if (pend_w1 && col_arm) begin
                  col_exp   = exp_acc(col_seg, col_off, 1'b0, col_la);
                  acc_valid = 1; acc_seg = 2'(col_seg); acc_offset = col_off; acc_write = 0;
                  col_arm   = 0;
                  col_pend  = 1;
               end
            end else
               dly--;
         end
         mem_rd_ready = (rcnt % 3) != 0;
         rcnt++;
         if (mem_rd_valid && mem_rd_ready && !pend) begin
            logic [31:0] e;
            e = (exp_reads.size() != 0) ? exp_reads.pop_front() : 32'hDEAD_BEEF;
            chk(mem_rd_addr == e, "R4 descriptor read address", mem_rd_addr, e);
            paddr   = mem_rd_addr;
            pend    = 1;
            pend_w1 = (rd_n % 2) == 1;
            dly     = rcnt % 2;
            rd_n++;
         end
      end
   end

   always @(negedge clk) if (rst_n && ld_done) n_dones++;

   initial begin : watchdog
      #(20ns * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      for (int i = 0; i < 4; i++) m_vld[i] = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0, "R1 busy after reset", 32'(busy), 0);
      chk(mem_rd_valid == 0, "R1 no read after reset", 32'(mem_rd_valid), 0);
      chk(ld_done == 0, "R1 no load completion", 32'(ld_done), 0);
      chk(acc_done == 0, "R1 no access completion", 32'(acc_done), 0);
      rst_n = 1;
      do_acc(0, 32'h10, 0, "R10 unloaded register");

      set_table(32'h0000_1000, 16'h003F);
      put_desc(1, 32'h0002_0000, 20'h00FFF, 4'b0010, 2'd3, 1, 0);
      put_desc(2, 32'h0040_0000, 20'h0000F, 4'b1010, 2'd0, 1, 1);
      put_desc(3, 32'h0003_0000, 20'h00FFF, 4'b0010, 2'd3, 0, 0);
      put_desc(4, 32'hFFFF_F000, 20'h01FFF, 4'b0000, 2'd3, 1, 0);
      put_desc(5, 32'h0000_5000, 20'h000FF, 4'b0010, 2'd1, 1, 0);
      put_desc(7, 32'h0000_7000, 20'h00010, 4'b0010, 2'd3, 1, 0);

      do_load(0, {13'd1, 1'b0, 2'd0}, 2'd0, 0, "R4 data load");
      do_acc(0, 32'h0, 0, "R7 base read");
      do_acc(0, 32'hFFF, 0, "R8 byte limit edge");
      do_acc(0, 32'h1000, 0, "R8 byte limit exceeded");
      do_acc(0, 32'h10, 1, "R9 write to writable data");

      do_load(1, {13'd2, 1'b0, 2'd0}, 2'd0, 0, "R4 code load");
      do_acc(1, 32'hFFFF, 0, "R8 granular edge");
      do_acc(1, 32'h1_0000, 0, "R8 granular exceeded");
      do_acc(1, 32'h4, 1, "R9 write to code");
      do_acc(1, 32'h1_0000, 1, "R9 limit before protection");

      do_load(2, {13'd3, 1'b0, 2'd0}, 2'd0, 0, "R5 absent descriptor");
      do_acc(2, 32'h0, 0, "R10 failed first load");
      do_load(2, {13'd5, 1'b0, 2'd2}, 2'd0, 0, "R6 requested level too weak");
      do_load(2, {13'd5, 1'b0, 2'd0}, 2'd2, 0, "R6 current level too weak");
      do_load(2, {13'd5, 1'b0, 2'd0}, 2'd1, 0, "R6 equal level passes");
      do_acc(2, 32'h20, 0, "R7 after privileged load");

      do_load(3, {13'd1, 1'b1, 2'd0}, 2'd0, 0, "R2 local table");
      do_load(3, {13'd8, 1'b0, 2'd0}, 2'd0, 0, "R3 beyond table");
      do_load(3, {13'd7, 1'b0, 2'd0}, 2'd0, 0, "R3 last table entry");
      do_load(3, {13'd4, 1'b0, 2'd3}, 2'd3, 0, "R4 read-only load");
      do_acc(3, 32'h1800, 0, "R7 address wraps");
      do_acc(3, 32'h10, 1, "R9 write to read-only data");
      do_acc(3, 32'h2000, 0, "R8 read-only limit exceeded");

      do_load(0, {13'd3, 1'b0, 2'd0}, 2'd0, 0, "R10 absent over loaded");
      do_acc(0, 32'h0, 0, "R10 previous entry kept");

      do_load(1, {13'd1, 1'b0, 2'd0}, 2'd0, 1, "R12 load with busy probe");
      do_acc(3, 32'h1800, 0, "R12 probe left register 3 alone");
      do_acc(1, 32'h10, 1, "R12 register 1 now data");

      col_seg = 0; col_off = 32'h10; col_arm = 1;
      do_load(0, {13'd5, 1'b0, 2'd0}, 2'd0, 0, "R11 load during collide");
      do_acc(0, 32'h10, 0, "R11 new entry afterwards");

      repeat (4) @(negedge clk);
      chk(n_dones == n_loads, "R12 one completion per accepted load", 32'(n_dones), 32'(n_loads));
      chk(exp_reads.size() == 0, "R4 all expected reads issued", 32'(exp_reads.size()), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule